// File: doc/BRIEF.md
# PME Turn-Off Handshake Controller

This block runs the power-management turn-off exchange for a single link. Software starts a sequence by writing 1 to a self-clearing send bit. The block then raises a transmit request toward the link's transmit side. It keeps the send bit set until the transmitter confirms that the turn-off message has actually gone out, and then waits for the acknowledge message to come back.

While the block waits, a timer counts microsecond ticks up to a limit picked by a 2-bit select field. The choices are about 1 ms, 10 ms or 50 ms, plus a 16-tick test setting. A disable bit removes the limit entirely. The sequence can end in two ways:

- The acknowledge arrives: the block gives a one-cycle done pulse and returns to idle.
- The limit is reached: the block sets a sticky timeout status bit, which software clears by writing 1, and returns to idle.

Message framing and the link power states are handled elsewhere.

Top module: `pme_turnoff_ctrl`

## Requirements
- R1: A write with `wr_en`=1 and `wr_send`=1 while the block is idle sets `send_bit` and `tx_req` in the next cycle. Both stay high until `tx_sent` is sampled.
- R2: `tx_sent` sampled high while `tx_req` is high clears `send_bit` and `tx_req` in the next cycle, and the acknowledge wait begins.
- R3: The 2-bit `tmo_sel` field selects the wait limit: value 0 selects TICKS_1MS ticks, 1 selects TICKS_10MS, 2 selects TICKS_50MS, and 3 selects 16 ticks (test mode). When the limit-th tick counted after the sent edge is sampled, `tmo_sts` reads 1 in the next cycle.
- R4: With `tmo_dis`=1 no timeout occurs, whatever the select field holds, and the block waits for the acknowledge with no limit.
- R5: `ack_rcvd` sampled during the wait gives `done`=1 for exactly one cycle, in the next cycle. The block then returns to idle. An acknowledge on the same edge as the limit tick takes precedence, and `tmo_sts` stays 0.
- R6: Out of reset, `send_bit`, `tmo_dis`, `tmo_sel`, `tmo_sts`, `tx_req` and `done` are all 0.
- R7: `tmo_sts` is sticky. A timeout also returns the block to idle, so a new send is accepted. A write with `wr_tmo_clr`=1 clears `tmo_sts` in the next cycle.
- R8: `ack_rcvd` while the block is idle is ignored, and `done` stays 0.
- R9: A send write while a sequence is running has no effect on `send_bit`, `tx_req` or the sequence in progress.
- R10: Any write loads `tmo_dis` and `tmo_sel`, which read back in the next cycle. The timer advances only on cycles where `us_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle microsecond time base pulse |
| wr_en | input | 1 | Control register write strobe |
| wr_send | input | 1 | Write data: 1 starts a turn-off sequence |
| wr_tmo_dis | input | 1 | Write data: timeout disable |
| wr_tmo_sel | input | 2 | Write data: timeout select |
| wr_tmo_clr | input | 1 | Write data: 1 clears the timeout status |
| tx_sent | input | 1 | Transmitter confirms the turn-off message was sent |
| ack_rcvd | input | 1 | Acknowledge message received |
| send_bit | output | 1 | Read-back of the self-clearing send bit |
| tmo_dis | output | 1 | Read-back of the timeout disable bit |
| tmo_sel | output | 2 | Read-back of the timeout select field |
| tmo_sts | output | 1 | Sticky timeout status |
| tx_req | output | 1 | Request to transmit the turn-off message |
| done | output | 1 | One-cycle pulse when the acknowledge ends the wait |

## Verification
Every result is due exactly one cycle after the edge that samples its cause:

- `send_bit` and `tx_req` follow the send write or `tx_sent`.
- `done` follows the acknowledge.
- `tmo_sts` follows the limit-th counted tick.
- The read-back fields follow their write.

The bench drives inputs on the falling edge and checks outputs on the next falling edge. It keeps its own arithmetic count of the ticks delivered since the sent edge. On every wait cycle it compares `tmo_sts` and `done` with what that count and the selected limit predict.

The sweeps cover:
- all four select codes;
- several tick spacings;
- acknowledges on every tick position up to and including the limit tick.

// File: rtl/pmeto_pkg.sv
// Package: shared types for the turn-off handshake controller.
// Assumes: imported by every module of the block.
package pmeto_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pmeto_cfg_regs.sv
// Module: control fields and sticky timeout status.
// Assumes: a write loads the disable and select fields every time;
// a timeout set on the same edge as a clear wins.
module pmeto_cfg_regs
    import pmeto_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_tmo_dis,
    input  logic [SEL_W-1:0] wr_tmo_sel,
    input  logic             wr_tmo_clr,
    input  logic             set_tmo,
    output logic             tmo_dis_q,
    output logic [SEL_W-1:0] tmo_sel_q,
    output logic             tmo_sts_q
);
    // Load the disable and select fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_dis_q <= 1'b0;
            tmo_sel_q <= '0;
        end else if (wr_en) begin
            tmo_dis_q <= wr_tmo_dis;
            tmo_sel_q <= wr_tmo_sel;
        end
    end

    // Sticky status: set by the timer, cleared by a write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmo_sts_q <= 1'b0;
        else if (set_tmo)
            tmo_sts_q <= 1'b1;
        else if (wr_en && wr_tmo_clr)
            tmo_sts_q <= 1'b0;
    end
endmodule

// File: rtl/pmeto_timer.sv
// Module: acknowledge wait timer.
// Counts us_tick pulses while run is high and flags expiry on the
// tick that reaches the selected limit.
// Assumes: every limit is at least 1; the counter restarts whenever
// run drops.
module pmeto_timer
    import pmeto_pkg::*;
#(
    parameter int TICKS_1MS  = 1000,
    parameter int TICKS_10MS = 10000,
    parameter int TICKS_50MS = 50000,
    parameter int TICKS_TEST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             dis,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int MAX_A = (TICKS_1MS > TICKS_10MS) ? TICKS_1MS : TICKS_10MS;
    localparam int MAX_B = (TICKS_50MS > TICKS_TEST) ? TICKS_50MS : TICKS_TEST;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    // Pick the count value whose tick ends the wait.
    always_comb begin
        unique case (sel)
            2'd0:    last_cnt = CNT_W'(TICKS_1MS - 1);
            2'd1:    last_cnt = CNT_W'(TICKS_10MS - 1);
            2'd2:    last_cnt = CNT_W'(TICKS_50MS - 1);
            default: last_cnt = CNT_W'(TICKS_TEST - 1);
        endcase
    end

    // Expiry is the limit-th tick of this wait with the timeout enabled.
    always_comb expire = run && !dis && tick && (cnt_q == last_cnt);

    // Count ticks during the wait, saturating, and restart when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (tick && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pmeto_seq.sv
// Module: turn-off handshake sequencer.
// States: idle, sending (transmit request held), waiting for the
// acknowledge.
// Assumes: an acknowledge and an expiry on the same edge resolve in
// favour of the acknowledge.
module pmeto_seq
    import pmeto_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       tx_sent,
    input  logic       ack,
    input  logic       expire,
    output seq_state_t state_q,
    output logic       done_q,
    output logic       set_tmo
);
    // A timeout is recorded only when no acknowledge arrives on that edge.
    always_comb set_tmo = (state_q == ST_WAIT) && !ack && expire;

    // Advance the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start)   state_q <= ST_SEND;
                ST_SEND: if (tx_sent) state_q <= ST_WAIT;
                ST_WAIT: if (ack || expire) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // One-cycle completion pulse for an acknowledge during the wait.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= (state_q == ST_WAIT) && ack;
    end
endmodule

// File: rtl/pme_turnoff_ctrl.sv
// Module: top of the turn-off handshake controller.
// Joins the control fields, the sequencer and the wait timer.
// Assumes: us_tick is a one-cycle pulse per microsecond; the
// transmitter holds off tx_sent until tx_req is seen.
module pme_turnoff_ctrl
    import pmeto_pkg::*;
#(
    parameter int TICKS_1MS  = 1000,
    parameter int TICKS_10MS = 10000,
    parameter int TICKS_50MS = 50000,
    parameter int TICKS_TEST = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       wr_en,
    input  logic       wr_send,
    input  logic       wr_tmo_dis,
    input  logic [1:0] wr_tmo_sel,
    input  logic       wr_tmo_clr,
    input  logic       tx_sent,
    input  logic       ack_rcvd,
    output logic       send_bit,
    output logic       tmo_dis,
    output logic [1:0] tmo_sel,
    output logic       tmo_sts,
    output logic       tx_req,
    output logic       done
);
    seq_state_t state;
    logic       expire;
    logic       set_tmo;

    pmeto_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_tmo_dis (wr_tmo_dis),
        .wr_tmo_sel (wr_tmo_sel),
        .wr_tmo_clr (wr_tmo_clr),
        .set_tmo    (set_tmo),
        .tmo_dis_q  (tmo_dis),
        .tmo_sel_q  (tmo_sel),
        .tmo_sts_q  (tmo_sts)
    );

    pmeto_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wr_en && wr_send),
        .tx_sent (tx_sent),
        .ack     (ack_rcvd),
        .expire  (expire),
        .state_q (state),
        .done_q  (done),
        .set_tmo (set_tmo)
    );

    pmeto_timer #(
        .TICKS_1MS  (TICKS_1MS),
        .TICKS_10MS (TICKS_10MS),
        .TICKS_50MS (TICKS_50MS),
        .TICKS_TEST (TICKS_TEST)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_WAIT),
        .tick   (us_tick),
        .dis    (tmo_dis),
        .sel    (tmo_sel),
        .expire (expire)
    );

    // The send bit reads 1 exactly while the message is pending.
    always_comb send_bit = (state == ST_SEND);
    always_comb tx_req   = (state == ST_SEND);
endmodule

// File: rtl/pmeto_chk.sv
// Module: protocol checker bound to the top module.
// Assumes: observes only the top module's ports.
module pmeto_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic wr_send,
    input logic wr_tmo_clr,
    input logic tx_sent,
    input logic ack_rcvd,
    input logic tx_req,
    input logic done,
    input logic tmo_sts,
    input logic tmo_dis
);
    // R1
    req_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> $past(wr_en && wr_send));

    // R2
    req_drops_after_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_sent) |=> !tx_req);

    // R4
    no_tmo_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_sts) |-> !$past(tmo_dis));

    // R5
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ack_rcvd));

    // R7
    sts_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmo_sts) |-> $past(wr_en && wr_tmo_clr));
endmodule

bind pme_turnoff_ctrl pmeto_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_send    (wr_send),
    .wr_tmo_clr (wr_tmo_clr),
    .tx_sent    (tx_sent),
    .ack_rcvd   (ack_rcvd),
    .tx_req     (tx_req),
    .done       (done),
    .tmo_sts    (tmo_sts),
    .tmo_dis    (tmo_dis)
);

// File: tb/tb_pme_turnoff_ctrl.sv
module tb_pme_turnoff_ctrl;
    localparam int L0 = 6;
    localparam int L1 = 11;
    localparam int L2 = 23;
    localparam int L3 = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0, wr_en = 1'b0, wr_send = 1'b0, wr_tmo_dis = 1'b0;
    logic [1:0] wr_tmo_sel = 2'd0;
    logic wr_tmo_clr = 1'b0, tx_sent = 1'b0, ack_rcvd = 1'b0;
    logic send_bit, tmo_dis, tmo_sts, tx_req, done;
    logic [1:0] tmo_sel;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pme_turnoff_ctrl #(.TICKS_1MS(L0), .TICKS_10MS(L1), .TICKS_50MS(L2)) dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_en(wr_en),
        .wr_send(wr_send), .wr_tmo_dis(wr_tmo_dis), .wr_tmo_sel(wr_tmo_sel),
        .wr_tmo_clr(wr_tmo_clr), .tx_sent(tx_sent), .ack_rcvd(ack_rcvd),
        .send_bit(send_bit), .tmo_dis(tmo_dis), .tmo_sel(tmo_sel),
        .tmo_sts(tmo_sts), .tx_req(tx_req), .done(done));

    function automatic int limit_of(int s);
        case (s)
            0: return L0;
            1: return L1;
            2: return L2;
            default: return L3;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write(bit snd, bit dis, int sel, bit clr);
        wr_en = 1; wr_send = snd; wr_tmo_dis = dis; wr_tmo_sel = 2'(sel); wr_tmo_clr = clr;
        @(negedge clk);
        wr_en = 0; wr_send = 0; wr_tmo_clr = 0;
    endtask

    // One full sequence; ack_at = 0 means no acknowledge before the limit.
    task automatic run_seq(int sel, bit dis, int period, int ack_at);
        int ticks = 0;
        int lim = limit_of(sel);
        write(1, dis, sel, 0);
        check("R1 tx_req", tx_req, 1);
        check("R1 send_bit", send_bit, 1);
        @(negedge clk); @(negedge clk);
        check("R1 held", tx_req, 1);
        tx_sent = 1;
        @(negedge clk);
        tx_sent = 0;
        check("R2 tx_req", tx_req, 0);
        check("R2 send_bit", send_bit, 0);
        for (int c = 0; c < 4 * lim * period + 20; c++) begin
            bit tk = (c % period) == (period - 1);
            int nt = ticks + (tk ? 1 : 0);
            bit ak = (ack_at > 0) && tk && (nt == ack_at);
            if (dis && c == lim) begin
                // R9: send write mid-wait has no effect
                wr_en = 1; wr_send = 1; wr_tmo_dis = dis; wr_tmo_sel = 2'(sel);
            end
            if (dis && ack_at == 0 && c == 4 * lim * period + 19) ak = 1;
            us_tick = tk; ack_rcvd = ak;
            @(negedge clk);
            us_tick = 0; ack_rcvd = 0; wr_en = 0; wr_send = 0;
            ticks = nt;
            if (dis && c == lim) begin
                check("R9 send_bit", send_bit, 0);
                check("R9 tx_req", tx_req, 0);
            end
            if (ak) begin
                check("R5 done", done, 1);
                check("R5 no tmo", tmo_sts, 0);
                @(negedge clk);
                check("R5 pulse", done, 0);
                break;
            end
            if (!dis && ticks >= lim) begin
                check("R3 tmo", tmo_sts, 1);
                check("R3 no done", done, 0);
                break;
            end
            if (dis) check("R4 no tmo", tmo_sts, 0);
            else     check("R3 early", tmo_sts, 0);
        end
        if (tmo_sts) begin
            @(negedge clk);
            check("R7 sticky", tmo_sts, 1);
            write(0, dis, sel, 1);
            check("R7 clear", tmo_sts, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R6 send_bit", send_bit, 0);
        check("R6 tx_req", tx_req, 0);
        check("R6 done", done, 0);
        check("R6 tmo_sts", tmo_sts, 0);
        check("R6 tmo_dis", tmo_dis, 0);
        check("R6 tmo_sel", tmo_sel, 0);
        rst_n = 1;
        @(negedge clk);
        // R8: acknowledge while idle
        ack_rcvd = 1; @(negedge clk); ack_rcvd = 0;
        check("R8 done", done, 0);
        @(negedge clk);
        check("R8 done later", done, 0);
        // R10: read-back of fields
        write(0, 1, 2, 0);
        check("R10 dis", tmo_dis, 1);
        check("R10 sel", tmo_sel, 2);
        write(0, 0, 3, 0);
        check("R10 dis0", tmo_dis, 0);
        check("R10 sel3", tmo_sel, 3);
        // Timeout sweep over every select code and tick spacing (R3, R10)
        for (int s = 0; s < 4; s++)
            for (int p = 1; p <= 3; p++)
                run_seq(s, 0, p, 0);
        // Acknowledge at every tick position, including the limit tick (R5)
        for (int s = 0; s < 4; s++)
            for (int k = 1; k <= limit_of(s); k++)
                run_seq(s, 0, 2, k);
        // Disabled timeout with each select (R4, R9)
        for (int s = 0; s < 4; s++)
            run_seq(s, 1, 1, 0);
        // Send write while the message is pending is ignored (R9)
        write(1, 0, 0, 0);
        write(1, 0, 0, 0);
        check("R9 pending", tx_req, 1);
        tx_sent = 1; @(negedge clk); tx_sent = 0;
        check("R9 one message", tx_req, 0);
        ack_rcvd = 1; @(negedge clk); ack_rcvd = 0;
        check("R9 done", done, 1);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule